// File: doc/BRIEF.md
# Configurable UART Transmitter

This block turns parallel characters into an asynchronous serial line. A character written into a one-entry holding register moves into a shift stage when the transmitter is enabled and the optional clear-to-send gate allows it. The shift stage then sends one frame made of a start bit, 7, 8 or 9 data bits, an optional parity bit and one or two stop bits. Every bit lasts sixteen pulses of an externally supplied oversampling enable, so the baud divider stays outside the block.

The frame options are fixed for a character at the moment it leaves the holding register. These options are the length, the parity, the stop count, the bit order and the data inversion. Polarity inversion of the whole line acts live on the pin. An interrupt pulse can mark either the moment the holding register frees up or the end of the last stop bit. This lets software choose between streaming characters back to back and knowing that the line has gone quiet.

Top module: `sertx_core`

## Requirements
- R1: After reset, buf_empty is 1, irq is 0 and txd sits at the idle level, which is 1 when cfg_line_inv is 0.
- R2: A frame starts with one start bit at level 0, followed by the data bits and then stop bits at level 1. Every bit lasts exactly 16 cycles in which tick_16x is 1. cfg_len picks the data length: 0 gives 7 bits, 1 gives 8 bits, 2 gives 9 bits and 3 gives 8 bits.
- R3: cfg_parity selects the parity bit, which follows the last data bit. A value of 0 or 3 sends no parity bit. A value of 1 gives even parity, where the parity bit equals the XOR of the data bits. A value of 2 gives odd parity, which is the inverse of that XOR. Parity is always computed on the data before inversion.
- R4: cfg_stop2 = 1 sends two stop bits; cfg_stop2 = 0 sends one.
- R5: cfg_msb_first = 0 sends wr_data bit 0 first. A value of 1 sends the highest selected bit first, which is bit 6, 7 or 8 depending on the length.
- R6: cfg_data_inv = 1 inverts only the data bits. The start bit, the parity bit and the stop bits keep their levels.
- R7: cfg_line_inv = 1 inverts every level on txd, including idle, and the change takes effect in the same cycle.
- R8: A character leaves the holding register only when tx_en is 1, the register is full, the shift stage is idle and the CTS condition allows it. The CTS condition allows it when cfg_cts_en is 0 or cts_n is 0.
- R9: While cfg_cts_en is 0, cts_n has no effect. cts_n is looked at only when a character is about to start, so raising it during a frame does not shorten that frame.
- R10: buf_empty is 1 exactly while the holding register can accept a character. A wr_en pulse while buf_empty is 0 is ignored, and the character already held is the one that is sent.
- R11: With cfg_irq_on_done = 0, irq is a one-cycle pulse in the first cycle of the start bit. In that cycle buf_empty is already 1 again.
- R12: With cfg_irq_on_done = 1, irq is a one-cycle pulse in the first cycle after the last stop bit has completed.
- R13: Changes to the length, parity, stop, order or data-inversion inputs during a frame do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_16x | input | 1 | Oversampling enable, 16 per bit |
| tx_en | input | 1 | Transmitter enable |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Character to send (low bits used for 7/8-bit lengths) |
| cfg_len | input | 2 | Data length select |
| cfg_parity | input | 2 | Parity select |
| cfg_stop2 | input | 1 | Two stop bits when 1 |
| cfg_msb_first | input | 1 | Most significant bit first when 1 |
| cfg_data_inv | input | 1 | Invert data bit values |
| cfg_line_inv | input | 1 | Invert the whole output line |
| cfg_cts_en | input | 1 | Enable the clear-to-send gate |
| cts_n | input | 1 | Clear to send, active low |
| cfg_irq_on_done | input | 1 | Interrupt at end of frame when 1, at register hand-over when 0 |
| txd | output | 1 | Serial output |
| buf_empty | output | 1 | Holding register can take a character |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions rely on a few assumptions about the inputs. cfg_line_inv may change at any time, and the bit-hold property allows for that. The interrupt mode input must be the same in the cycle that starts or ends a frame as it was one cycle earlier, since the interrupt properties read it through $past. The stimulus only changes cfg_irq_on_done while the transmitter is idle with an empty register. It drives all other inputs half a cycle away from the active edge. The bench varies the tick spacing and toggles the line polarity, cts_n and the framing inputs in the middle of frames, so that the properties are exercised exactly where they claim tolerance.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   typedef enum logic [1:0] {
      LEN_7   = 2'd0,
      LEN_8   = 2'd1,
      LEN_9   = 2'd2,
      LEN_ALT = 2'd3
   } char_len_e;

   typedef enum logic [1:0] {
      PAR_NONE = 2'd0,
      PAR_EVEN = 2'd1,
      PAR_ODD  = 2'd2,
      PAR_OFF  = 2'd3
   } parity_e;

   typedef struct packed {
      char_len_e len;
      parity_e   par;
      logic      stop2;
      logic      msb_first;
      logic      data_inv;
   } frame_cfg_t;

   // number of data bits carried for a length code
   function automatic int unsigned char_bits(char_len_e l);
      case (l)
         LEN_7:   return 7;
         LEN_9:   return 9;
         default: return 8;
      endcase
   endfunction

endpackage

// File: rtl/sertx_framer.sv
// Builds the whole frame as a vector sent from bit 0 upward.
module sertx_framer
   import sertx_pkg::*;
#(
   parameter int MAX_CHAR = 9,
   parameter int FRAME_W  = MAX_CHAR + 4,
   parameter int CNT_W    = $clog2(FRAME_W + 1)
) (
   input  logic [MAX_CHAR-1:0] chr,
   input  frame_cfg_t          cfg,
   output logic [FRAME_W-1:0]  frame,
   output logic [CNT_W-1:0]    nbits
);

   logic [CNT_W-1:0]    n;
   logic [MAX_CHAR-1:0] valid;
   logic [MAX_CHAR-1:0] ordered;
   logic                par_on;
   logic                par_bit;

   assign n = CNT_W'(char_bits(cfg.len));

   // per-position data selection for both bit orders
   for (genvar k = 0; k < MAX_CHAR; k++) begin : g_pos
      logic [CNT_W-1:0] src;
      assign src        = n - CNT_W'(1) - CNT_W'(k);
      assign valid[k]   = (CNT_W'(k) < n);
      assign ordered[k] = !valid[k]      ? 1'b0 :
                          cfg.msb_first ? chr[src] : chr[k];
   end

   // parity over the raw (uninverted) selected bits
   assign par_on  = (cfg.par == PAR_EVEN) || (cfg.par == PAR_ODD);
   assign par_bit = (^(chr & valid)) ^ (cfg.par == PAR_ODD);

   always_comb begin
      frame    = '1;
      frame[0] = 1'b0;
      for (int k = 0; k < MAX_CHAR; k++) begin
         if (valid[k]) frame[k + 1] = ordered[k] ^ cfg.data_inv;
      end
      if (par_on) frame[n + CNT_W'(1)] = par_bit;
   end

   assign nbits = CNT_W'(1) + n + CNT_W'(par_on) + (cfg.stop2 ? CNT_W'(2) : CNT_W'(1));

endmodule

// File: rtl/sertx_holdbuf.sv
// One-entry holding register in front of the shift stage.
module sertx_holdbuf #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         take,
   output logic         full,
   output logic [W-1:0] data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         data <= '0;
      end else if (take) begin
         full <= 1'b0;
      end else if (wr_en && !full) begin
         full <= 1'b1;
         data <= wr_data;
      end
   end

endmodule

// File: rtl/sertx_shifter.sv
// Bit timing and serialisation of one frame.
module sertx_shifter #(
   parameter int FRAME_W    = 13,
   parameter int CNT_W      = 4,
   parameter int OVERSAMPLE = 16,
   parameter int TCNT_W     = $clog2(OVERSAMPLE)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame,
   input  logic [CNT_W-1:0]   nbits,
   output logic               busy,
   output logic               line_bit,
   output logic               done
);

   localparam logic [TCNT_W-1:0] TLAST = TCNT_W'(OVERSAMPLE - 1);

   logic [FRAME_W-1:0] sh;
   logic [CNT_W-1:0]   left;
   logic [TCNT_W-1:0]  tcnt;
   logic               edge_bit;

   assign edge_bit = busy && tick && (tcnt == TLAST);
   assign done     = edge_bit && (left == CNT_W'(1));
   assign line_bit = busy ? sh[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '1;
         left <= '0;
         tcnt <= '0;
         busy <= 1'b0;
      end else if (load) begin
         sh   <= frame;
         left <= nbits;
         tcnt <= '0;
         busy <= 1'b1;
      end else if (busy && tick) begin
         if (edge_bit) begin
            tcnt <= '0;
            sh   <= {1'b1, sh[FRAME_W-1:1]};
            left <= left - CNT_W'(1);
            if (left == CNT_W'(1)) busy <= 1'b0;
         end else begin
            tcnt <= tcnt + TCNT_W'(1);
         end
      end
   end

endmodule

// File: rtl/sertx_core.sv
module sertx_core
   import sertx_pkg::*;
#(
   parameter int MAX_CHAR   = 9,
   parameter int OVERSAMPLE = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_16x,
   input  logic                tx_en,
   input  logic                wr_en,
   input  logic [MAX_CHAR-1:0] wr_data,
   input  logic [1:0]          cfg_len,
   input  logic [1:0]          cfg_parity,
   input  logic                cfg_stop2,
   input  logic                cfg_msb_first,
   input  logic                cfg_data_inv,
   input  logic                cfg_line_inv,
   input  logic                cfg_cts_en,
   input  logic                cts_n,
   input  logic                cfg_irq_on_done,
   output logic                txd,
   output logic                buf_empty,
   output logic                irq
);

   localparam int FRAME_W = MAX_CHAR + 4;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   if (MAX_CHAR != 9) begin : g_bad_width
      $error("sertx_core: character formats require MAX_CHAR == 9");
   end
   if (OVERSAMPLE < 2) begin : g_bad_os
      $error("sertx_core: OVERSAMPLE must be at least 2");
   end

   logic                hold_full;
   logic [MAX_CHAR-1:0] hold_data;
   logic                busy;
   logic                line_bit;
   logic                done;
   logic                cts_ok;
   logic                load;
   logic [FRAME_W-1:0]  frame;
   logic [CNT_W-1:0]    nbits;
   frame_cfg_t          fcfg;

   assign fcfg.len       = char_len_e'(cfg_len);
   assign fcfg.par       = parity_e'(cfg_parity);
   assign fcfg.stop2     = cfg_stop2;
   assign fcfg.msb_first = cfg_msb_first;
   assign fcfg.data_inv  = cfg_data_inv;

   assign cts_ok = !cfg_cts_en || !cts_n;
   assign load   = tx_en && hold_full && !busy && cts_ok;

   sertx_holdbuf #(.W(MAX_CHAR)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .take    (load),
      .full    (hold_full),
      .data    (hold_data)
   );

   sertx_framer #(.MAX_CHAR(MAX_CHAR), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_frame (
      .chr   (hold_data),
      .cfg   (fcfg),
      .frame (frame),
      .nbits (nbits)
   );

   sertx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W), .OVERSAMPLE(OVERSAMPLE)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_16x),
      .load     (load),
      .frame    (frame),
      .nbits    (nbits),
      .busy     (busy),
      .line_bit (line_bit),
      .done     (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= cfg_irq_on_done ? done : load;
   end

   assign txd       = line_bit ^ cfg_line_inv;
   assign buf_empty = !hold_full;

endmodule

// File: rtl/sertx_checks.sv
module sertx_checks #(
   parameter int CW = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tick_16x,
   input logic          tx_en,
   input logic          cts_n,
   input logic          cfg_cts_en,
   input logic          cfg_line_inv,
   input logic          cfg_irq_on_done,
   input logic          txd,
   input logic          buf_empty,
   input logic          irq,
   input logic          busy,
   input logic [CW-1:0] hold_data
);

   // R1 / R7: an idle line shows the polarity-adjusted high level
   a_r1_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (txd == !cfg_line_inv ^ 1'b0));

   // R2: first cycle of a frame carries the start level
   a_r2_start_level: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (txd == cfg_line_inv));

   // R2: the line only moves on a tick or a polarity change
   a_r2_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick_16x) |=> ($stable(txd) || !$stable(cfg_line_inv)));

   // R8: a frame only starts under the enable, full and CTS conditions
   a_r8_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(tx_en) && !$past(buf_empty) &&
                       (!$past(cfg_cts_en) || !$past(cts_n))));

   // R10: held character cannot be overwritten while full
   a_r10_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !buf_empty |=> $stable(hold_data));

   // R11: hand-over frees the register
   a_r11_empty_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> buf_empty);

   // R11: hand-over interrupt
   a_r11_irq_on_load: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && !$past(cfg_irq_on_done)) |-> irq);

   // R12: end-of-frame interrupt
   a_r12_irq_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && $past(cfg_irq_on_done)) |-> irq);

endmodule

bind sertx_core sertx_checks #(.CW(MAX_CHAR)) u_checks (
   .clk             (clk),
   .rst_n           (rst_n),
   .tick_16x        (tick_16x),
   .tx_en           (tx_en),
   .cts_n           (cts_n),
   .cfg_cts_en      (cfg_cts_en),
   .cfg_line_inv    (cfg_line_inv),
   .cfg_irq_on_done (cfg_irq_on_done),
   .txd             (txd),
   .buf_empty       (buf_empty),
   .irq             (irq),
   .busy            (busy),
   .hold_data       (hold_data)
);

// File: tb/sertx_core_tb.sv
module sertx_core_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_16x = 1'b0;
   logic       tx_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [8:0] wr_data = '0;
   logic [1:0] cfg_len = 2'd1;
   logic [1:0] cfg_parity = 2'd0;
   logic       cfg_stop2 = 1'b0;
   logic       cfg_msb_first = 1'b0;
   logic       cfg_data_inv = 1'b0;
   logic       cfg_line_inv = 1'b0;
   logic       cfg_cts_en = 1'b0;
   logic       cts_n = 1'b1;
   logic       cfg_irq_on_done = 1'b0;
   logic       txd, buf_empty, irq;

   always #10 clk = ~clk;

   sertx_core u_dut (
      .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x), .tx_en(tx_en),
      .wr_en(wr_en), .wr_data(wr_data), .cfg_len(cfg_len), .cfg_parity(cfg_parity),
      .cfg_stop2(cfg_stop2), .cfg_msb_first(cfg_msb_first), .cfg_data_inv(cfg_data_inv),
      .cfg_line_inv(cfg_line_inv), .cfg_cts_en(cfg_cts_en), .cts_n(cts_n),
      .cfg_irq_on_done(cfg_irq_on_done), .txd(txd), .buf_empty(buf_empty), .irq(irq)
   );

   int    n_checks = 0;
   int    n_fail = 0;
   int    irq_seen = 0;
   int    cycles = 0;
   string cur_req = "R1";

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   // ---------------- tick generator ----------------
   int tick_div = 2;
   int tick_ctr = 0;
   always @(negedge clk) begin
      tick_ctr = (tick_ctr + 1 >= tick_div) ? 0 : tick_ctr + 1;
      tick_16x <= (tick_ctr == 0);
   end

   // ---------------- behavioural reference ----------------
   bit         m_full = 0;
   logic [8:0] m_data = '0;
   bit         m_busy = 0;
   int         m_cnt = 0;
   bit         m_q[$];
   bit         m_irq = 0;

   function automatic void build_frame(logic [8:0] d);
      int n;
      int ones;
      bit b;
      n = (cfg_len == 2'd0) ? 7 : (cfg_len == 2'd2) ? 9 : 8;
      ones = 0;
      m_q.delete();
      m_q.push_back(1'b0);
      for (int i = 0; i < n; i++) begin
         b = cfg_msb_first ? d[n-1-i] : d[i];
         m_q.push_back(b ^ cfg_data_inv);
         ones += int'(d[i]);
      end
      if (cfg_parity == 2'd1) m_q.push_back(bit'(ones % 2));
      if (cfg_parity == 2'd2) m_q.push_back(!bit'(ones % 2));
      m_q.push_back(1'b1);
      if (cfg_stop2) m_q.push_back(1'b1);
   endfunction

   always @(posedge clk) begin : ref_model
      bit ld, wok, irq_n;
      if (!rst_n) begin
         m_full = 0; m_busy = 0; m_cnt = 0; m_q.delete(); m_irq = 0;
      end else begin
         ld  = !m_busy && m_full && tx_en && (!cfg_cts_en || !cts_n);
         wok = wr_en && !m_full;
         irq_n = 0;
         if (m_busy && tick_16x) begin
            m_cnt++;
            if (m_cnt == 16) begin
               m_cnt = 0;
               void'(m_q.pop_front());
               if (m_q.size() == 0) begin
                  m_busy = 0;
                  if (cfg_irq_on_done) irq_n = 1;
               end
            end
         end
         if (ld) begin
            build_frame(m_data);
            m_busy = 1; m_cnt = 0; m_full = 0;
            if (!cfg_irq_on_done) irq_n = 1;
         end
         if (wok) begin
            m_full = 1; m_data = wr_data;
         end
         m_irq = irq_n;
      end
   end

   // ---------------- per-cycle comparison ----------------
   always begin
      @(negedge clk);
      #5;
      begin
         bit exp_txd;
         exp_txd = (m_busy ? m_q[0] : 1'b1) ^ cfg_line_inv;
         check(txd == exp_txd, cur_req, "txd", int'(txd), int'(exp_txd));
         check(buf_empty == !m_full, cur_req, "buf_empty", int'(buf_empty), int'(!m_full));
         check(irq == m_irq, cur_req, "irq", int'(irq), int'(m_irq));
         if (irq) irq_seen++;
      end
   end

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         check(1'b0, "watchdog", "cycles", cycles, 150000);
         finish_run();
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic push_char(logic [8:0] d);
      while (m_full) step();
      wr_en   = 1'b1;
      wr_data = d;
      step();
      wr_en   = 1'b0;
   endtask

   task automatic drain();
      while (m_full || m_busy) step();
      step(2);
   endtask

   task automatic send_one(string req, logic [8:0] d);
      cur_req  = req;
      irq_seen = 0;
      push_char(d);
      drain();
      check(irq_seen == 1, req, "irq pulses per frame", irq_seen, 1);
   endtask

   // ---------------- sequence ----------------
   initial begin
      step(3);
      #5;
      check(txd == 1'b1, "R1", "reset txd", int'(txd), 1);
      check(buf_empty == 1'b1, "R1", "reset buf_empty", int'(buf_empty), 1);
      check(irq == 1'b0, "R1", "reset irq", int'(irq), 0);
      step();
      rst_n = 1'b1;
      step(2);
      tx_en = 1'b1;

      // R2: plain frames of each length
      cfg_len = 2'd1; send_one("R2", 9'h05A);
      cfg_len = 2'd0; send_one("R2", 9'h07F);
      cfg_len = 2'd2; send_one("R2", 9'h1C3);
      cfg_len = 2'd3; send_one("R2", 9'h0A5);

      // R3: parity variants
      cfg_len = 2'd1; cfg_parity = 2'd1; send_one("R3", 9'h0B7);
      cfg_len = 2'd0; cfg_parity = 2'd2; send_one("R3", 9'h045);
      cfg_parity = 2'd3; send_one("R3", 9'h033);

      // R4: two stop bits
      cfg_len = 2'd2; cfg_parity = 2'd2; cfg_stop2 = 1'b1; send_one("R4", 9'h1A5);
      cfg_stop2 = 1'b0; cfg_parity = 2'd0;

      // R5: MSB first
      cfg_msb_first = 1'b1;
      send_one("R5", 9'h10F);
      cfg_len = 2'd0; send_one("R5", 9'h031);
      cfg_msb_first = 1'b0; cfg_len = 2'd1;

      // R6: data inversion with parity
      cfg_data_inv = 1'b1; cfg_parity = 2'd1; send_one("R6", 9'h00F);
      cfg_data_inv = 1'b0; cfg_parity = 2'd0;

      // R7: line inversion, idle and mid-frame toggle
      cur_req = "R7";
      cfg_line_inv = 1'b1; step(5);
      #5 check(txd == 1'b0, "R7", "inverted idle", int'(txd), 0);
      step();
      push_char(9'h0C9);
      step(100); cfg_line_inv = 1'b0;
      step(100); cfg_line_inv = 1'b1;
      drain();
      cfg_line_inv = 1'b0;

      // R8: enable gate and CTS gate
      cur_req = "R8";
      tx_en = 1'b0;
      push_char(9'h066);
      step(100);
      #5 check(buf_empty == 1'b0, "R8", "held while disabled", int'(buf_empty), 0);
      step();
      check(txd == 1'b1, "R8", "idle while disabled", int'(txd), 1);
      cfg_cts_en = 1'b1; cts_n = 1'b1; tx_en = 1'b1;
      step(100);
      #5 check(buf_empty == 1'b0, "R8", "held while CTS high", int'(buf_empty), 0);
      step();
      cts_n = 1'b0;
      drain();

      // R9: CTS disabled ignored, mid-frame CTS rise harmless
      cur_req = "R9";
      cfg_cts_en = 1'b0; cts_n = 1'b1;
      send_one("R9", 9'h0E1);
      cfg_cts_en = 1'b1; cts_n = 1'b0;
      push_char(9'h01E);
      step(60); cts_n = 1'b1;
      drain();
      cts_n = 1'b0; cfg_cts_en = 1'b0;

      // R10: write while full ignored
      cur_req = "R10";
      tx_en = 1'b0;
      push_char(9'h055);
      wr_en = 1'b1; wr_data = 9'h0AA; step(); wr_en = 1'b0;
      #5 check(buf_empty == 1'b0, "R10", "still full after extra write", int'(buf_empty), 0);
      step();
      tx_en = 1'b1;
      drain();

      // R11: back-to-back streaming with hand-over interrupts
      cur_req = "R11";
      irq_seen = 0;
      push_char(9'h011);
      push_char(9'h022);
      push_char(9'h033);
      drain();
      check(irq_seen == 3, "R11", "hand-over pulses", irq_seen, 3);

      // R12: end-of-frame interrupt
      cfg_irq_on_done = 1'b1;
      step(2);
      send_one("R12", 9'h0F0);
      cur_req = "R12";
      irq_seen = 0;
      push_char(9'h00A);
      push_char(9'h0A0);
      drain();
      check(irq_seen == 2, "R12", "done pulses", irq_seen, 2);
      cfg_irq_on_done = 1'b0;
      step(2);

      // R13: framing inputs changed mid-frame
      cur_req = "R13";
      cfg_len = 2'd1; cfg_parity = 2'd1;
      push_char(9'h0C3);
      step(40);
      cfg_len = 2'd2; cfg_parity = 2'd2; cfg_stop2 = 1'b1;
      cfg_msb_first = 1'b1; cfg_data_inv = 1'b1;
      drain();
      cfg_stop2 = 1'b0; cfg_msb_first = 1'b0; cfg_data_inv = 1'b0;

      // R2: uneven tick spacing
      tick_div = 3;
      cfg_len = 2'd1; cfg_parity = 2'd0;
      send_one("R2", 9'h096);
      tick_div = 1;
      send_one("R2", 9'h169);

      finish_run();
   end

endmodule